// File: doc/BRIEF.md
# Configurable Pin Cell

This block sits between one device pin and the core logic. A three-bit mode field turns it into one of five kinds of pin: a plain combinational input, an input sampled on an I/O clock, an input held by a level-sensitive latch, an output-only pin, or a bidirectional pin whose driver is switched by the core. A separate bit inverts the outgoing data so that the pin can be active high or active low. Another bit picks which of two I/O clock lines the input storage follows.

All storage runs on the core clock `clk`. The two I/O clock lines are sampled as levels. A sampled input takes the pad value in the core cycle where the selected line is seen to rise. The latch copies the pad value in every core cycle in which the selected line is high, and holds it otherwise. An active-low reset, `rst_n`, clears both stores and the edge history without waiting for a clock. The pin signals have no handshake. They are level signals that the cell updates every cycle.

Top module: `pin_cell`

## Requirements
- R1: With `cfg_mode` = 0, `core_in` equals `pad_in` in the same cycle and `pad_oe` is 0.
- R2: With `cfg_mode` = 1, `core_in` shows the pad value from the core clock edge where the selected line is high after being low at the previous edge. `core_in` keeps that value until the next such rise, even if the pad changes or the line stays high.
- R3: With `cfg_mode` = 2, `core_in` takes the pad value at every core clock edge where the selected line is high. It holds its value at every edge where that line is low.
- R4: With `cfg_mode` = 3, `pad_oe` is 1 whatever `core_oe` is, and `core_in` reads 0.
- R5: With `cfg_mode` = 4, `pad_oe` equals `core_oe` and `core_in` equals `pad_in` in the same cycle.
- R6: `pad_out` equals `core_out` when `cfg_invert` = 0 and its complement when `cfg_invert` = 1, in every mode. `pad_oe` is never inverted.
- R7: `cfg_clk_sel` = 0 selects `ioclk_a` and `cfg_clk_sel` = 1 selects `ioclk_b`. Activity on the line that is not selected has no effect on the stored input.
- R8: While `rst_n` is 0, the sampled and latched values and the edge history are 0, so `core_in` reads 0 in modes 1 and 2.
- R9: The codes 5, 6 and 7 behave like code 0: the input passes straight through and `pad_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 3 | Pin mode: 0 comb in, 1 sampled in, 2 latched in, 3 output, 4 bidirectional |
| cfg_invert | input | 1 | 1 makes the output active low |
| cfg_clk_sel | input | 1 | I/O clock line select: 0 line A, 1 line B |
| ioclk_a | input | 1 | I/O clock line A (level) |
| ioclk_b | input | 1 | I/O clock line B (level) |
| pad_in | input | W | Value seen at the pin |
| pad_out | output | W | Value to drive on the pin |
| pad_oe | output | 1 | Pin driver enable |
| core_out | input | W | Output data from core logic |
| core_oe | input | 1 | Output enable from core logic |
| core_in | output | W | Input result to core logic |

## Verification
The hardest behaviour to reach from the ports is the sampled input's refusal to take new data. This covers a line held high across several cycles, a rise on the line that is not selected, and a change of line select while an old edge is still in the history. The stimulus steps each I/O clock line by hand, one core cycle at a time. It changes the pad only while the selected line stays high, pulses the other line, and lowers the new line before switching to it. This way every one of those rise-or-no-rise cases has a known expected value.

// File: rtl/pin_cell_pkg.sv
package pin_cell_pkg;
  typedef enum logic [2:0] {
    PM_COMB  = 3'd0,
    PM_REG   = 3'd1,
    PM_LATCH = 3'd2,
    PM_OUT   = 3'd3,
    PM_BIDIR = 3'd4
  } pin_mode_e;

  localparam int MODE_W = 3;
endpackage

// File: rtl/iocell_clk_pick.sv
module iocell_clk_pick (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic line_a,
  input  logic line_b,
  output logic level,
  output logic rise
);
  logic level_q;

  assign level = sel ? line_b : line_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign rise = level & ~level_q;
endmodule

// File: rtl/iocell_capture.sv
module iocell_capture #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         level,
  input  logic         rise,
  input  logic [W-1:0] d,
  output logic [W-1:0] q_reg,
  output logic [W-1:0] q_lat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_reg <= '0;
      q_lat <= '0;
    end else begin
      if (rise)  q_reg <= d;
      if (level) q_lat <= d;
    end
  end
endmodule

// File: rtl/iocell_drive.sv
module iocell_drive
  import pin_cell_pkg::*;
#(
  parameter int W = 1
) (
  input  logic [MODE_W-1:0] mode,
  input  logic              invert,
  input  logic [W-1:0]      core_out,
  input  logic              core_oe,
  output logic [W-1:0]      pad_out,
  output logic              pad_oe
);
  assign pad_out = core_out ^ {W{invert}};

  always_comb begin
    case (mode)
      PM_OUT:   pad_oe = 1'b1;
      PM_BIDIR: pad_oe = core_oe;
      default:  pad_oe = 1'b0;
    endcase
  end
endmodule

// File: rtl/pin_cell.sv
module pin_cell
  import pin_cell_pkg::*;
#(
  parameter int W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic              cfg_invert,
  input  logic              cfg_clk_sel,
  input  logic              ioclk_a,
  input  logic              ioclk_b,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_out,
  output logic              pad_oe,
  input  logic [W-1:0]      core_out,
  input  logic              core_oe,
  output logic [W-1:0]      core_in
);
  logic         lvl, rse;
  logic [W-1:0] q_reg, q_lat;

  iocell_clk_pick u_pick (
    .clk(clk), .rst_n(rst_n), .sel(cfg_clk_sel),
    .line_a(ioclk_a), .line_b(ioclk_b), .level(lvl), .rise(rse)
  );

  iocell_capture #(.W(W)) u_cap (
    .clk(clk), .rst_n(rst_n), .level(lvl), .rise(rse),
    .d(pad_in), .q_reg(q_reg), .q_lat(q_lat)
  );

  iocell_drive #(.W(W)) u_drv (
    .mode(cfg_mode), .invert(cfg_invert), .core_out(core_out),
    .core_oe(core_oe), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always_comb begin
    case (cfg_mode)
      PM_REG:   core_in = q_reg;
      PM_LATCH: core_in = q_lat;
      PM_OUT:   core_in = '0;
      default:  core_in = pad_in;
    endcase
  end
endmodule

// File: rtl/pin_cell_chk.sv
module pin_cell_chk
  import pin_cell_pkg::*;
#(
  parameter int W = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MODE_W-1:0] cfg_mode,
  input logic              cfg_invert,
  input logic              cfg_clk_sel,
  input logic              ioclk_a,
  input logic              ioclk_b,
  input logic [W-1:0]      pad_in,
  input logic [W-1:0]      pad_out,
  input logic              pad_oe,
  input logic [W-1:0]      core_out,
  input logic              core_oe,
  input logic [W-1:0]      core_in
);
  logic       line_now;
  logic [1:0] armed;

  assign line_now = cfg_clk_sel ? ioclk_b : ioclk_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         armed <= 2'd0;
    else if (armed != 2'd3) armed <= armed + 2'd1;
  end

  AST_COMB_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 3'd0) |-> (core_in == pad_in && !pad_oe)); // R1

  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (armed == 2'd3 && cfg_mode == 3'd1 && $past(cfg_mode) == 3'd1 &&
     $stable(cfg_clk_sel) && $past(cfg_clk_sel, 2) == cfg_clk_sel &&
     !($past(line_now) && !$past(line_now, 2))) |-> $stable(core_in)); // R2

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (armed != 2'd0 && cfg_mode == 3'd2 && $past(cfg_mode) == 3'd2 &&
     $stable(cfg_clk_sel) && !$past(line_now)) |-> $stable(core_in)); // R3

  AST_OUT_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 3'd3) |-> (pad_oe && core_in == '0)); // R4

  AST_BIDIR_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 3'd4) |-> (pad_oe == core_oe && core_in == pad_in)); // R5

  AST_POL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (armed != 2'd0 && $stable(core_out) && !$stable(cfg_invert)) |->
    (pad_out == ~$past(pad_out))); // R6

  AST_RSVD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode > 3'd4) |-> (!pad_oe && core_in == pad_in)); // R9
endmodule

bind pin_cell pin_cell_chk #(.W(W)) u_chk (.*);

// File: tb/sim_pin_cell.sv
module sim_pin_cell;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cfg_mode = 3'd0;
  logic       cfg_invert = 1'b0;
  logic       cfg_clk_sel = 1'b0;
  logic       ioclk_a = 1'b0;
  logic       ioclk_b = 1'b0;
  logic [0:0] pad_in = 1'b0;
  logic [0:0] pad_out;
  logic       pad_oe;
  logic [0:0] core_out = 1'b0;
  logic       core_oe = 1'b0;
  logic [0:0] core_in;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  pin_cell #(.W(1)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_invert(cfg_invert),
    .cfg_clk_sel(cfg_clk_sel), .ioclk_a(ioclk_a), .ioclk_b(ioclk_b),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .core_out(core_out), .core_oe(core_oe), .core_in(core_in)
  );

  // {mode, invert, core_out, core_oe, pad_in, exp_oe, exp_out, exp_in}
  localparam int NV = 10;
  localparam logic [9:0] VEC [NV] = '{
    {3'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},  // R1
    {3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},  // R1 R6
    {3'd3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},  // R4
    {3'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},  // R4 R6
    {3'd4, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},  // R5
    {3'd4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R5
    {3'd4, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},  // R5 R6
    {3'd5, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},  // R9
    {3'd6, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // R9
    {3'd7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}   // R9
  };

  task automatic chk(input string req, input logic [0:0] act, input logic [0:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    ioclk_a = 1'b0;
    ioclk_b = 1'b0;
    tick();
    @(negedge clk);
    rst_n = 1'b1;
    tick();
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    tick();
    cfg_mode = 3'd1;
    #0.5;
    chk("R8 sampled value in reset", core_in, 1'b0);
    cfg_mode = 3'd2;
    #0.5;
    chk("R8 latched value in reset", core_in, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {cfg_mode, cfg_invert, core_out, core_oe, pad_in} = VEC[i][9:3];
      #1;
      chk("R1/R4/R5/R9 pad_oe", pad_oe, VEC[i][2]);
      chk("R6 pad_out", pad_out, VEC[i][1]);
      chk("R1/R4/R5/R9 core_in", core_in, VEC[i][0]);
    end

    // R2 sampled input on line A
    @(negedge clk); cfg_mode = 3'd1; cfg_invert = 1'b0; cfg_clk_sel = 1'b0;
    do_reset();
    @(negedge clk); pad_in = 1'b1; tick();
    chk("R2 no rise no capture", core_in, 1'b0);
    @(negedge clk); ioclk_a = 1'b1; tick();
    chk("R2 capture on rise", core_in, 1'b1);
    @(negedge clk); pad_in = 1'b0; tick();
    chk("R2 hold while line high", core_in, 1'b1);
    @(negedge clk); ioclk_a = 1'b0; tick();
    chk("R2 hold on fall", core_in, 1'b1);
    // R7 unselected line ignored
    @(negedge clk); ioclk_b = 1'b1; tick();
    chk("R7 line B ignored", core_in, 1'b1);
    @(negedge clk); ioclk_b = 1'b0; tick();
    @(negedge clk); cfg_clk_sel = 1'b1; tick();
    chk("R7 switch to B no capture", core_in, 1'b1);
    @(negedge clk); ioclk_b = 1'b1; tick();
    chk("R7 capture on B rise", core_in, 1'b0);
    @(negedge clk); pad_in = 1'b1; ioclk_a = 1'b1; tick();
    chk("R7 line A ignored when B chosen", core_in, 1'b0);

    // R3 latched input on line A
    @(negedge clk); cfg_mode = 3'd2; cfg_clk_sel = 1'b0; ioclk_b = 1'b0;
    do_reset();
    chk("R8 latch cleared", core_in, 1'b0);
    @(negedge clk); ioclk_a = 1'b1; pad_in = 1'b1; tick();
    chk("R3 transparent takes 1", core_in, 1'b1);
    @(negedge clk); pad_in = 1'b0; tick();
    chk("R3 transparent takes 0", core_in, 1'b0);
    @(negedge clk); pad_in = 1'b1; tick();
    @(negedge clk); ioclk_a = 1'b0; tick();
    @(negedge clk); pad_in = 1'b0; tick();
    chk("R3 hold while line low", core_in, 1'b1);
    @(negedge clk); ioclk_b = 1'b1; tick();
    chk("R7 latch ignores line B", core_in, 1'b1);
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R8 reset clears latch at once", core_in, 1'b0);
    @(negedge clk); rst_n = 1'b1; ioclk_b = 1'b0; tick();

    // R6 polarity on enable in bidirectional mode
    @(negedge clk); cfg_mode = 3'd4; core_oe = 1'b1; cfg_invert = 1'b1; #1;
    chk("R6 enable not inverted", pad_oe, 1'b1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule